// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer

This block turns a 32-bit virtual byte address into a 32-bit physical byte address using a small table of recently used page translations. Pages are 4 KB. The low 12 address bits are the byte offset inside the page and pass straight through. The 20 bits above them form the virtual page number, and each table entry maps one virtual page number to a 20-bit physical page number.

The table has 16 entries and is direct-mapped. The four lowest virtual page number bits pick exactly one entry. The remaining 16 page bits are stored with that entry as its tag and compared on every lookup.

A lookup request is answered one clock later with a response strobe, a hit flag, the physical address and three permission/state flags. When a lookup misses, the surrounding logic fetches the translation elsewhere and installs it through a separate refill port. A single flush input drops every translation at once.

Top module: `tlbXlate`

## Requirements
- R1: `respValid` is high in the cycle after a cycle with `lookupValid` high, and low in the cycle after a cycle with `lookupValid` low.
- R2: A lookup selects the entry given by `lookupVaddr[15:12]`. It hits only when that entry is valid and its stored tag equals `lookupVaddr[31:16]`.
- R3: On a hit, `respPaddr[31:12]` is the stored physical page number and `respPaddr[11:0]` equals `lookupVaddr[11:0]` of the request.
- R4: On a hit, `respFlags` returns the stored flags. Bit 0 means read allowed, bit 1 means write allowed and bit 2 means dirty.
- R5: A refill (`fillEn` high, `flushAll` low) makes the entry `fillVaddr[15:12]` valid, holding tag `fillVaddr[31:16]`, page `fillPpn` and flags `fillFlags`. From the next cycle on it replaces any earlier contents of that entry. A lookup issued in the same cycle as the refill sees the old contents.
- R6: `flushAll` invalidates all 16 entries in one cycle. Lookups issued in later cycles miss until a refill is made.
- R7: When `flushAll` and `fillEn` are high in the same cycle, the flush wins and the refilled entry stays invalid.
- R8: After reset every entry is invalid and `respValid` and `respHit` are low. A miss, or a cycle with no response, drives `respHit` low.
- R9: Two pages that share index bits `[15:12]` but differ in tag evict each other: after a refill of one, a lookup of the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVaddr | input | 32 | Virtual byte address to translate |
| fillEn | input | 1 | Install a translation this cycle |
| fillVaddr | input | 32 | Virtual address whose page is being installed |
| fillPpn | input | 20 | Physical page number to install |
| fillFlags | input | 3 | Flags to install (bit 0 read, bit 1 write, bit 2 dirty) |
| flushAll | input | 1 | Invalidate every entry |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respHit | output | 1 | Translation found |
| respPaddr | output | 32 | Physical byte address, meaningful only on a hit |
| respFlags | output | 3 | Flags of the hit entry, meaningful only on a hit |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a refill and a lookup of the same page in one cycle, which must still miss. The other is a refill and a flush in one cycle, where the flush must win. Directed sequences place these events on exactly the same clock edge. After each one they issue follow-up lookups that show the table contents before and after the edge.

A long pseudo-random phase then draws virtual pages from a small pool with shared index bits. This produces frequent hits, conflict evictions and overlapping fill, flush and lookup traffic. A behavioural table model is compared against the design every cycle throughout.

// File: rtl/tlbPkg.sv
package tlbPkg;
  // address geometry
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 4;
  localparam int FLAG_W  = 3;
  // derived widths
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int TAG_W   = VPN_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  // flag bit positions
  localparam int FLAG_READ  = 0;
  localparam int FLAG_WRITE = 1;
  localparam int FLAG_DIRTY = 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } tlbEntryT;

  // strobes from control to datapath
  typedef struct packed {
    logic             writeEn;
    logic             clearAll;
    logic [IDX_W-1:0] writeIdx;
    logic             captureResp;
    logic [IDX_W-1:0] readIdx;
  } tlbStrobeT;
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic            lookupValid,
  input  logic [VA_W-1:0] lookupVaddr,
  input  logic            fillEn,
  input  logic [VA_W-1:0] fillVaddr,
  input  logic            flushAll,
  output tlbStrobeT       strobe
);
  always_comb begin
    strobe             = '0;
    // flush has priority over refill
    strobe.clearAll    = flushAll;
    strobe.writeEn     = fillEn & ~flushAll;
    strobe.writeIdx    = fillVaddr[OFF_W +: IDX_W];
    strobe.captureResp = lookupValid;
    strobe.readIdx     = lookupVaddr[OFF_W +: IDX_W];
  end
endmodule

// File: rtl/tlbTable.sv
module tlbTable
  import tlbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  tlbStrobeT strobe,
  input  tlbEntryT  wrEntry,
  output tlbEntryT  rdEntry,
  output logic      rdValid
);
  tlbEntryT             entryMem [ENTRIES];
  logic [ENTRIES-1:0]   validVec;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
    logic selHere;
    assign selHere = strobe.writeEn && (strobe.writeIdx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                validVec[gi] <= 1'b0;
      else if (strobe.clearAll) validVec[gi] <= 1'b0;
      else if (selHere)         validVec[gi] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selHere) entryMem[gi] <= wrEntry;
    end
  end

  // combinational read, old contents visible during a same-cycle write
  assign rdEntry = entryMem[strobe.readIdx];
  assign rdValid = validVec[strobe.readIdx];
endmodule

// File: rtl/tlbMatch.sv
module tlbMatch
  import tlbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobeT        strobe,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [OFF_W-1:0] reqOffset,
  input  tlbEntryT         rdEntry,
  input  logic             rdValid,
  output logic             respValid,
  output logic             respHit,
  output logic [PA_W-1:0]  respPaddr,
  output logic [FLAG_W-1:0] respFlags
);
  logic tagEq;
  logic hitNow;

  assign tagEq  = (rdEntry.tag == reqTag);
  assign hitNow = strobe.captureResp & rdValid & tagEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
    end else begin
      respValid <= strobe.captureResp;
      respHit   <= hitNow;
    end
  end

  // data path needs no reset: qualified by respHit
  always_ff @(posedge clk) begin
    if (strobe.captureResp) begin
      respPaddr <= {rdEntry.ppn, reqOffset};
      respFlags <= rdEntry.flags;
    end
  end
endmodule

// File: rtl/tlbXlate.sv
module tlbXlate
  import tlbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic              fillEn,
  input  logic [VA_W-1:0]   fillVaddr,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [FLAG_W-1:0] fillFlags,
  input  logic              flushAll,
  output logic              respValid,
  output logic              respHit,
  output logic [PA_W-1:0]   respPaddr,
  output logic [FLAG_W-1:0] respFlags
);
  tlbStrobeT strobe;
  tlbEntryT  wrEntry;
  tlbEntryT  rdEntry;
  logic      rdValid;

  tlbCtrl u_ctrl (
    .lookupValid (lookupValid),
    .lookupVaddr (lookupVaddr),
    .fillEn      (fillEn),
    .fillVaddr   (fillVaddr),
    .flushAll    (flushAll),
    .strobe      (strobe)
  );

  assign wrEntry.tag   = fillVaddr[VA_W-1 -: TAG_W];
  assign wrEntry.ppn   = fillPpn;
  assign wrEntry.flags = fillFlags;

  tlbTable u_table (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrEntry (wrEntry),
    .rdEntry (rdEntry),
    .rdValid (rdValid)
  );

  tlbMatch u_match (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqTag    (lookupVaddr[VA_W-1 -: TAG_W]),
    .reqOffset (lookupVaddr[OFF_W-1:0]),
    .rdEntry   (rdEntry),
    .rdValid   (rdValid),
    .respValid (respValid),
    .respHit   (respHit),
    .respPaddr (respPaddr),
    .respFlags (respFlags)
  );
endmodule

// File: rtl/tlbXlateChecker.sv
module tlbXlateChecker
  import tlbPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [VA_W-1:0]   lookupVaddr,
  input logic              fillEn,
  input logic [VA_W-1:0]   fillVaddr,
  input logic [PPN_W-1:0]  fillPpn,
  input logic              flushAll,
  input logic              respValid,
  input logic              respHit,
  input logic [PA_W-1:0]   respPaddr
);
  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R8
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respHit);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!respHit || respPaddr[OFF_W-1:0] == $past(lookupVaddr[OFF_W-1:0])));

  // R6
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll ##1 lookupValid |=> !respHit);

  // R5
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushAll) ##1
    (lookupValid && lookupVaddr[VA_W-1:OFF_W] == $past(fillVaddr[VA_W-1:OFF_W]))
    |=> (respHit && respPaddr[PA_W-1:OFF_W] == $past(fillPpn, 2)));
endmodule

bind tlbXlate tlbXlateChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .lookupVaddr (lookupVaddr),
  .fillEn      (fillEn),
  .fillVaddr   (fillVaddr),
  .fillPpn     (fillPpn),
  .flushAll    (flushAll),
  .respValid   (respValid),
  .respHit     (respHit),
  .respPaddr   (respPaddr)
);

// File: tb/test_tlbXlate.sv
`timescale 1ns/1ps
module test_tlbXlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic        fillEn = 1'b0;
  logic [31:0] fillVaddr = '0;
  logic [19:0] fillPpn = '0;
  logic [2:0]  fillFlags = '0;
  logic        flushAll = 1'b0;
  logic        respValid, respHit;
  logic [31:0] respPaddr;
  logic [2:0]  respFlags;

  always #2.5 clk = ~clk;

  tlbXlate i_tlbXlate (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .fillEn(fillEn), .fillVaddr(fillVaddr), .fillPpn(fillPpn),
    .fillFlags(fillFlags), .flushAll(flushAll),
    .respValid(respValid), .respHit(respHit),
    .respPaddr(respPaddr), .respFlags(respFlags)
  );

  int checks = 0;
  int errors = 0;
  bit running = 1'b1;
  string curReq = "R8";
  string expReq = "R8";

  // behavioural reference table
  logic        mValid [16];
  logic [15:0] mTag   [16];
  logic [19:0] mPpn   [16];
  logic [2:0]  mFlags [16];
  logic        expValid, expHit;
  logic [31:0] expPaddr;
  logic [2:0]  expFlags;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 16; k++) mValid[k] <= 1'b0;
      expValid <= 1'b0;
      expHit   <= 1'b0;
      expReq   <= curReq;
    end else begin
      expReq   <= curReq;
      expValid <= lookupValid;
      expHit   <= lookupValid && mValid[lookupVaddr[15:12]] &&
                  (mTag[lookupVaddr[15:12]] == lookupVaddr[31:16]);
      expPaddr <= {mPpn[lookupVaddr[15:12]], lookupVaddr[11:0]};
      expFlags <= mFlags[lookupVaddr[15:12]];
      if (flushAll) begin
        for (int k = 0; k < 16; k++) mValid[k] <= 1'b0;
      end else if (fillEn) begin
        mValid[fillVaddr[15:12]] <= 1'b1;
        mTag[fillVaddr[15:12]]   <= fillVaddr[31:16];
        mPpn[fillVaddr[15:12]]   <= fillPpn;
        mFlags[fillVaddr[15:12]] <= fillFlags;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (respValid !== expValid || respHit !== expHit) begin
        errors++;
        $display("FAIL %s valid/hit actual=%b/%b expected=%b/%b t=%0t",
                 expReq, respValid, respHit, expValid, expHit, $time);
      end else if (expHit && (respPaddr !== expPaddr || respFlags !== expFlags)) begin
        errors++;
        $display("FAIL %s paddr/flags actual=%h/%b expected=%h/%b t=%0t",
                 expReq, respPaddr, respFlags, expPaddr, expFlags, $time);
      end
    end
  end

  task automatic drive(input logic lv, input logic [31:0] lva,
                       input logic fe, input logic [31:0] fva,
                       input logic [19:0] fp, input logic [2:0] ff,
                       input logic fl, input string req);
    @(negedge clk);
    lookupValid = lv; lookupVaddr = lva;
    fillEn = fe; fillVaddr = fva; fillPpn = fp; fillFlags = ff;
    flushAll = fl; curReq = req;
  endtask

  task automatic look(input logic [31:0] va, input string req);
    drive(1'b1, va, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] p,
                      input logic [2:0] f, input string req);
    drive(1'b0, '0, 1'b1, va, p, f, 1'b0, req);
  endtask

  task automatic idle(input string req);
    drive(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic finishRun();
    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000 && running) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R8");
    look(32'h1234_5678, "R8");        // empty table misses
    idle("R1");
    // R3 / R4: install and hit
    fill(32'h1234_5000, 20'hABCDE, 3'b101, "R5");
    look(32'h1234_5678, "R3");
    look(32'h1234_5FFF, "R4");
    look(32'h9234_5678, "R2");        // same index, other tag
    look(32'h1234_6678, "R2");        // other index
    // R2: fill every index, then back-to-back lookups
    for (int i = 0; i < 16; i++)
      fill({16'h0100 + 16'(i), 4'(i), 12'h000}, 20'h50000 + 20'(i * 7), 3'(i), "R5");
    for (int i = 0; i < 16; i++)
      look({16'h0100 + 16'(i), 4'(i), 12'(i * 33)}, "R2");
    idle("R1");
    // R5: fill and lookup of the same page in one cycle sees old contents
    drive(1'b1, 32'h7777_5123, 1'b1, 32'h7777_5000, 20'h11111, 3'b011, 1'b0, "R5");
    look(32'h7777_5123, "R5");
    // R9: conflicting page at index 5 evicts it
    fill(32'h8888_5000, 20'h22222, 3'b110, "R9");
    look(32'h7777_5123, "R9");
    look(32'h8888_5ABC, "R9");
    // R6: flush
    drive(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, "R6");
    look(32'h8888_5ABC, "R6");
    look(32'h0103_3000, "R6");
    // R7: flush beats refill
    fill(32'h4444_2000, 20'h33333, 3'b001, "R7");
    drive(1'b0, '0, 1'b1, 32'h4444_2000, 20'h33333, 3'b001, 1'b1, "R7");
    look(32'h4444_2010, "R7");
    idle("R7");
    // random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] va, fa;
      va = {13'h0, 3'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 12'($urandom)};
      fa = {13'h0, 3'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 12'h000};
      drive(1'($urandom_range(0, 3) != 0), va,
            1'($urandom_range(0, 3) == 0), fa, 20'($urandom), 3'($urandom),
            1'($urandom_range(0, 63) == 0), "R2");
    end
    idle("R1");
    idle("R1");
    @(negedge clk);
    finishRun();
  end
endmodule